// File: doc/BRIEF.md
# I2C Target Own-Address Register and Address Matcher

This block holds the programmable own address of an I2C target and decides whether each address byte delivered by the target's bit engine should be acknowledged. Software writes and reads one 32-bit configuration word on a bus clock. The word holds an enable, a 7-bit/10-bit mode select and a ten-bit address field. The address compare runs on a separate kernel clock. The bit engine feeds it received bytes with a one-cycle valid strobe, plus a pulse that marks a stop or a repeated start. For each address byte the block returns a registered response: a valid flag, the ACK decision, a flag that shows the full address has matched, and the read/write direction bit.

The address field and the mode bit are locked while the enable is set. The enable bit itself can always be written. Each accepted write travels into the kernel domain through a toggle handshake. A write that arrives while the previous one is still in flight is held off with a wait signal until the handshake returns. Reads never wait.

Top module: `i2c_own_addr_unit`

## Requirements
- R1: After reset, reg_rdata reads 0x0000_0000, reg_wait is 0 and resp_valid is 0.
- R2: The register reads the enable at bit 15, the 10-bit mode at bit 10 and the address at bits 9:0. Bits 31:16 and 14:11 always read 0, whatever value was written to them.
- R3: A write accepted while the current enable is 1 updates only the enable. Bits 10:0 keep their old value. A write accepted while the enable is 0 updates bits 15, 10 and 9:0.
- R4: In 7-bit mode (bit 10 = 0) with the enable set, the first byte after a stop or repeated start is acknowledged exactly when byte[7:1] equals address bits 7:1. Address bits 9, 8 and 0 take no part in the compare. resp_dir equals byte[0], resp_hit equals resp_ack, and the response appears one kernel clock after rx_valid.
- R5: In 10-bit mode with the enable set, the first byte is acknowledged only when it equals {5'b11110, address[9:8], 1'b0}. This ACK has resp_hit = 0.
- R6: After an acknowledged 10-bit header, the next byte is acknowledged, with resp_hit = 1 and resp_dir = 0, exactly when it equals address bits 7:0. Otherwise it is NACKed.
- R7: With the enable at 0, every address byte gets resp_valid = 1 and resp_ack = 0.
- R8: After a final ACK or a NACK decision, further bytes produce no response until bus_event pulses. A bus_event pulse, including one in the middle of a 10-bit address, returns the matcher to first-byte matching.
- R9: A write presented while an earlier write is still crossing into the kernel domain sees reg_wait = 1 and is not taken until reg_wait falls. The wait lasts at most 16 bus cycles.
- R10: A write with no earlier write in flight completes with reg_wait = 0. reg_rdata shows the new value in the cycle after the accepting edge. reg_wait is never 1 without reg_wr.
- R11: A new configuration governs matching once the handshake has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| reg_wr | input | 1 | Write request, held until reg_wait is low |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents |
| reg_wait | output | 1 | Wait state for a write that overlaps one still in flight |
| ker_clk | input | 1 | I2C kernel clock |
| ker_rst | input | 1 | Synchronous active-high reset, kernel domain |
| rx_byte | input | 8 | Received address byte |
| rx_valid | input | 1 | One-cycle strobe marking rx_byte |
| bus_event | input | 1 | Stop or repeated start seen |
| resp_valid | output | 1 | A decision is presented this cycle |
| resp_ack | output | 1 | Acknowledge the byte |
| resp_hit | output | 1 | The complete own address has matched |
| resp_dir | output | 1 | Read/write bit of the address |

## Verification
A corrupted bus-side configuration shows up in reg_rdata on the cycle after the accepting edge, so every register check reads back right away. A wrong kernel copy or a wrong matcher state only shows up on the next address byte, one kernel cycle after rx_valid. For that reason the 7-bit compare, the 10-bit header and the 10-bit second byte are each swept over all 256 byte values for several addresses. A stuck handshake shows up as reg_wait held high on the next write, which the wait-length bound catches within 16 bus cycles.

// File: rtl/i2c_oa_pkg.sv
package i2c_oa_pkg;
    localparam int OA_W    = 10;
    localparam int REG_W   = 32;
    localparam int EN_BIT  = 15;
    localparam int TEN_BIT = 10;
    localparam logic [4:0] TEN_HDR = 5'b11110;

    typedef struct packed {
        logic            en;
        logic            ten;
        logic [OA_W-1:0] addr;
    } oa_cfg_t;

    typedef struct packed {
        logic valid;
        logic ack;
        logic hit;
        logic dir;
    } oa_resp_t;

    typedef enum logic [1:0] {M_IDLE, M_TEN2, M_HOLD} mstate_t;

    // Apply a register write under the lock rule: fields frozen while enabled.
    function automatic oa_cfg_t cfg_write(oa_cfg_t cur, logic [REG_W-1:0] wd);
        oa_cfg_t nxt;
        nxt    = cur;
        nxt.en = wd[EN_BIT];
        if (!cur.en) begin
            nxt.ten  = wd[TEN_BIT];
            nxt.addr = wd[OA_W-1:0];
        end
        return nxt;
    endfunction

    function automatic logic [REG_W-1:0] cfg_read(oa_cfg_t c);
        logic [REG_W-1:0] r;
        r            = '0;
        r[EN_BIT]    = c.en;
        r[TEN_BIT]   = c.ten;
        r[OA_W-1:0]  = c.addr;
        return r;
    endfunction
endpackage

// File: rtl/oa_sync.sv
module oa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/oa_bus_regs.sv
module oa_bus_regs
    import i2c_oa_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             ack_tgl,
    output oa_cfg_t          cfg,
    output logic             req_tgl,
    output logic             wait_o,
    output logic [REG_W-1:0] rdata
);
    logic ack_s;
    logic busy;
    logic take;

    oa_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk(bus_clk), .rst(bus_rst), .d(ack_tgl), .q(ack_s)
    );

    assign busy   = req_tgl ^ ack_s;
    assign take   = wr & ~busy;
    assign wait_o = wr & busy;
    assign rdata  = cfg_read(cfg);

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            cfg     <= '0;
            req_tgl <= 1'b0;
        end else if (take) begin
            cfg     <= cfg_write(cfg, wdata);
            req_tgl <= ~req_tgl;
        end
    end
endmodule

// File: rtl/oa_ker_cdc.sv
module oa_ker_cdc
    import i2c_oa_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic    ker_clk,
    input  logic    ker_rst,
    input  logic    req_tgl,
    input  oa_cfg_t cfg_in,
    output oa_cfg_t cfg_out,
    output logic    ack_tgl
);
    logic req_s;

    oa_sync #(.STAGES(SYNC)) u_req_sync (
        .clk(ker_clk), .rst(ker_rst), .d(req_tgl), .q(req_s)
    );

    // cfg_in is held stable by the bus side until ack_tgl comes back.
    always_ff @(posedge ker_clk) begin
        if (ker_rst) begin
            cfg_out <= '0;
            ack_tgl <= 1'b0;
        end else begin
            ack_tgl <= req_s;
            if (req_s != ack_tgl) cfg_out <= cfg_in;
        end
    end
endmodule

// File: rtl/oa_matcher.sv
module oa_matcher
    import i2c_oa_pkg::*;
(
    input  logic     ker_clk,
    input  logic     ker_rst,
    input  oa_cfg_t  cfg,
    input  logic [7:0] rx_byte,
    input  logic     rx_valid,
    input  logic     bus_event,
    output oa_resp_t resp
);
    mstate_t  st, st_nxt;
    oa_resp_t rn;
    logic     seven_ok, hdr_ok, low_ok;

    assign seven_ok = rx_byte[7:1] == cfg.addr[7:1];
    assign hdr_ok   = (rx_byte[7:3] == TEN_HDR) && (rx_byte[2:1] == cfg.addr[9:8]) && !rx_byte[0];
    assign low_ok   = rx_byte == cfg.addr[7:0];

    always_comb begin
        st_nxt = st;
        rn     = '0;
        if (bus_event) begin
            st_nxt = M_IDLE;
        end else if (rx_valid) begin
            case (st)
                M_IDLE: begin
                    rn.valid = 1'b1;
                    rn.dir   = rx_byte[0];
                    if (!cfg.ten) begin
                        rn.ack = cfg.en & seven_ok;
                        rn.hit = cfg.en & seven_ok;
                        st_nxt = M_HOLD;
                    end else begin
                        rn.ack = cfg.en & hdr_ok;
                        st_nxt = (cfg.en & hdr_ok) ? M_TEN2 : M_HOLD;
                    end
                end
                M_TEN2: begin
                    rn.valid = 1'b1;
                    rn.ack   = cfg.en & low_ok;
                    rn.hit   = cfg.en & low_ok;
                    st_nxt   = M_HOLD;
                end
                default: st_nxt = M_HOLD;
            endcase
        end
    end

    always_ff @(posedge ker_clk) begin
        if (ker_rst) begin
            st   <= M_IDLE;
            resp <= '0;
        end else begin
            st   <= st_nxt;
            resp <= rn;
        end
    end
endmodule

// File: rtl/i2c_own_addr_unit.sv
module i2c_own_addr_unit
    import i2c_oa_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic        bus_clk,
    input  logic        bus_rst,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_wait,
    input  logic        ker_clk,
    input  logic        ker_rst,
    input  logic [7:0]  rx_byte,
    input  logic        rx_valid,
    input  logic        bus_event,
    output logic        resp_valid,
    output logic        resp_ack,
    output logic        resp_hit,
    output logic        resp_dir
);
    oa_cfg_t  b_cfg, k_cfg;
    oa_resp_t resp;
    logic     req_tgl, ack_tgl;

    oa_bus_regs #(.SYNC(SYNC)) u_regs (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .wr(reg_wr), .wdata(reg_wdata),
        .ack_tgl(ack_tgl), .cfg(b_cfg), .req_tgl(req_tgl), .wait_o(reg_wait),
        .rdata(reg_rdata)
    );

    oa_ker_cdc #(.SYNC(SYNC)) u_cdc (
        .ker_clk(ker_clk), .ker_rst(ker_rst), .req_tgl(req_tgl),
        .cfg_in(b_cfg), .cfg_out(k_cfg), .ack_tgl(ack_tgl)
    );

    oa_matcher u_match (
        .ker_clk(ker_clk), .ker_rst(ker_rst), .cfg(k_cfg), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .bus_event(bus_event), .resp(resp)
    );

    assign resp_valid = resp.valid;
    assign resp_ack   = resp.ack;
    assign resp_hit   = resp.hit;
    assign resp_dir   = resp.dir;
endmodule

// File: rtl/oa_chk.sv
module oa_chk #(
    parameter int WAIT_LIMIT = 16
) (
    input logic        bus_clk,
    input logic        bus_rst,
    input logic        ker_clk,
    input logic        ker_rst,
    input logic        reg_wr,
    input logic        reg_wait,
    input logic [31:0] reg_rdata,
    input logic        rx_valid,
    input logic        bus_event,
    input logic        resp_valid,
    input logic        resp_ack,
    input logic        resp_hit,
    input logic        kcfg_en
);
    int unsigned wait_run;

    always_ff @(posedge bus_clk) begin
        if (bus_rst)       wait_run <= 0;
        else if (reg_wait) wait_run <= wait_run + 1;
        else               wait_run <= 0;
    end

    // R1
    reset_clear_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $past(bus_rst) |-> (reg_rdata == 32'h0) && !reg_wait);
    // R2
    reserved_zero_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (reg_rdata[31:16] == 16'h0) && (reg_rdata[14:11] == 4'h0));
    // R3
    field_lock_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (reg_wr && !reg_wait && reg_rdata[15]) |=> $stable(reg_rdata[10:0]));
    // R9
    wait_bound_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        wait_run <= WAIT_LIMIT);
    // R10
    wait_on_write_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
        reg_wait |-> reg_wr);
    // R6
    hit_implies_ack_chk: assert property (@(posedge ker_clk) disable iff (ker_rst)
        resp_hit |-> resp_ack && resp_valid);
    // R7
    disabled_nack_chk: assert property (@(posedge ker_clk) disable iff (ker_rst)
        (!kcfg_en && rx_valid) |=> !resp_ack);
    // R8
    event_silent_chk: assert property (@(posedge ker_clk) disable iff (ker_rst)
        bus_event |=> !resp_valid);
endmodule

bind i2c_own_addr_unit oa_chk #(.WAIT_LIMIT(16)) u_chk (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .ker_clk(ker_clk), .ker_rst(ker_rst),
    .reg_wr(reg_wr), .reg_wait(reg_wait), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .bus_event(bus_event), .resp_valid(resp_valid),
    .resp_ack(resp_ack), .resp_hit(resp_hit), .kcfg_en(k_cfg.en)
);

// File: tb/sim_i2c_own_addr_unit.sv
`timescale 1ns/1ps
module sim_i2c_own_addr_unit;
    localparam int BUS_PERIOD = 10;
    localparam int KER_PERIOD = 14;

    logic        bus_clk = 0, ker_clk = 0, bus_rst = 1, ker_rst = 1;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        reg_wait;
    logic [7:0]  rx_byte = 0;
    logic        rx_valid = 0, bus_event = 0;
    logic        resp_valid, resp_ack, resp_hit, resp_dir;

    int ncmp = 0, nerr = 0;
    bit done = 0;

    always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
    always #(KER_PERIOD/2) ker_clk = ~ker_clk;

    i2c_own_addr_unit u0 (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [31:0] d, output int waits);
        @(negedge bus_clk);
        reg_wr = 1; reg_wdata = d; waits = 0;
        #1;
        while (reg_wait) begin
            waits++;
            @(negedge bus_clk);
            #1;
        end
        @(negedge bus_clk);
        reg_wr = 0;
    endtask

    task automatic settle();
        repeat (20) @(negedge bus_clk);
    endtask

    task automatic wr_settle(logic [31:0] d);
        int w;
        bus_write(d, w);
        settle();
    endtask

    task automatic evt();
        @(negedge ker_clk) bus_event = 1;
        @(negedge ker_clk) bus_event = 0;
    endtask

    task automatic send(logic [7:0] b, output logic [3:0] r);
        @(negedge ker_clk) begin rx_byte = b; rx_valid = 1; end
        @(negedge ker_clk) rx_valid = 0;
        r = {resp_valid, resp_ack, resp_hit, resp_dir};
    endtask

    // Clear enable first so address/mode fields are writable (R3).
    task automatic configure(logic en, logic ten, logic [9:0] a);
        wr_settle(32'h0);
        wr_settle({16'h0, en, 4'h0, ten, a});
    endtask

    initial begin
        repeat (2000000) @(posedge bus_clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
            $finish;
        end
    end

    initial begin
        logic [3:0] r;
        int w;
        logic [9:0] a7 [4];
        logic [9:0] a10 [3];
        logic [7:0] hdr;
        a7[0] = 10'h155; a7[1] = 10'h02A; a7[2] = 10'h381; a7[3] = 10'h0FE;
        a10[0] = 10'h2B7; a10[1] = 10'h100; a10[2] = 10'h0FF;

        repeat (4) @(negedge ker_clk);
        bus_rst = 0; ker_rst = 0;
        @(negedge bus_clk); #1;
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 wait", {31'h0, reg_wait}, 32'h0);
        chk("R1 resp_valid", {31'h0, resp_valid}, 32'h0);

        // R2 / R3 register layout and lock
        wr_settle(32'hFFFF_FFFF);
        chk("R2 layout", reg_rdata, 32'h0000_87FF);
        wr_settle(32'h0000_8123);
        chk("R3 locked fields", reg_rdata, 32'h0000_87FF);
        wr_settle(32'h0000_0000);
        chk("R3 enable writable", reg_rdata, 32'h0000_07FF);
        wr_settle(32'h5A5A_F955);
        chk("R2 reserved ignored", reg_rdata, 32'h0000_8155);

        // R4 7-bit sweeps
        for (int i = 0; i < 4; i++) begin
            configure(1'b1, 1'b0, a7[i]);
            for (int b = 0; b < 256; b++) begin
                logic m;
                m = (b[7:1] == a7[i][7:1]);
                evt();
                send(b[7:0], r);
                chk("R4 seven-bit", {28'h0, r}, {28'h0, 1'b1, m, m, b[0]});
            end
            evt();
            send({a7[i][7:1], 1'b1}, r);
            chk("R4 read dir", {28'h0, r}, 32'h0000_000F);
            send({a7[i][7:1], 1'b0}, r);
            chk("R8 hold silent", {28'h0, r}, 32'h0);
        end

        // R7 disabled
        configure(1'b0, 1'b0, 10'h155);
        for (int b = 0; b < 256; b++) begin
            evt();
            send(b[7:0], r);
            chk("R7 disabled", {28'h0, r[3:1]}, 32'h4);
        end
        configure(1'b0, 1'b1, 10'h2B7);
        evt();
        send(8'hF4, r);
        chk("R7 disabled 10-bit", {28'h0, r[3:1]}, 32'h4);

        // R5 / R6 10-bit sweeps
        for (int i = 0; i < 3; i++) begin
            configure(1'b1, 1'b1, a10[i]);
            hdr = {5'b11110, a10[i][9:8], 1'b0};
            for (int b = 0; b < 256; b++) begin
                logic m;
                m = (b[7:0] == hdr);
                evt();
                send(b[7:0], r);
                chk("R5 header", {28'h0, r}, {28'h0, 1'b1, m, 1'b0, b[0]});
            end
            for (int b = 0; b < 256; b++) begin
                logic m;
                m = (b[7:0] == a10[i][7:0]);
                evt();
                send(hdr, r);
                send(b[7:0], r);
                chk("R6 second byte", {28'h0, r}, {28'h0, 1'b1, m, m, 1'b0});
                send(a10[i][7:0], r);
                chk("R8 hold after decision", {28'h0, r}, 32'h0);
            end
            // R8 restart mid-address returns to header matching
            evt();
            send(hdr, r);
            evt();
            send(a10[i][7:0], r);
            chk("R8 restart mid", {28'h0, r},
                {28'h0, 1'b1, (a10[i][7:0] == hdr), 1'b0, a10[i][0]});
            evt();
            send(8'h00, r);
            send(hdr, r);
            chk("R8 hold after nack", {28'h0, r}, 32'h0);
        end

        // R9 / R10 / R11 stall on overlapping writes
        wr_settle(32'h0);
        bus_write(32'h0000_0011, w);
        chk("R10 isolated no wait", w, 0);
        #1;
        chk("R10 readback immediate", reg_rdata, 32'h0000_0011);
        bus_write(32'h0000_8422, w);
        chk("R9 stalled", {31'h0, (w > 0)}, 32'h1);
        chk("R9 bounded", {31'h0, (w <= 16)}, 32'h1);
        #1;
        chk("R9 second applied", reg_rdata, 32'h0000_8422);
        settle();
        evt();
        send({5'b11110, 2'b00, 1'b0}, r);
        chk("R11 new config used", {28'h0, r}, 32'h0000_000C);
        send(8'h22, r);
        chk("R11 new config low byte", {28'h0, r}, 32'h0000_000E);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end
endmodule